// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope analog-to-digital converter. It runs the converter through three phases in a fixed order: auto-zero, signal integrate and reference deintegrate. It counts clocks in each phase and drives one select output per phase, so the analog switches always know which phase is active. A comparator, seen here as a single digital level, is sampled at the end of integrate to give the polarity. A change of that level during deintegrate marks the zero crossing. The deintegrate clock count at that crossing is the conversion magnitude.

A run/hold input controls when conversions happen. Held high, conversions follow one another. Held low, the sequencer finishes its minimum auto-zero and then waits in auto-zero. A rising run/hold starts the next conversion after a fixed delay, and the busy flag rises at that same moment. If run/hold is low after the crossing, the rest of the deintegrate window is skipped. Each result is kept in an output latch as a magnitude with a polarity bit and an overrange bit. The busy flag falls in the same cycle that new data is written to the latch.

Top module: `ds_seq`

## Requirements
- R1: While rst_ni is low, az_o is 1, int_o and deint_o are 0, status_o is 0, and mag_o, pol_o and ovr_o are 0.
- R2: Exactly one of az_o, int_o and deint_o is high in every cycle.
- R3: run_i has no effect until the sequencer has spent AZ_MIN clock edges in auto-zero. A high run_i during that span does not start a conversion.
- R4: After the minimum auto-zero, the first edge that samples run_i high starts a countdown of START_DLY edges. On the last of these edges int_o and status_o go high. Once the countdown has started, it completes whatever run_i does. While run_i stays low, the sequencer remains in auto-zero.
- R5: Integrate lasts exactly INT_LEN clock edges. The level of cmp_i at the last integrate edge becomes the conversion polarity, and deint_o then goes high.
- R6: The deintegrate count is 0 at the first deintegrate edge and rises by 1 per edge. At the first deintegrate edge where cmp_i differs from the polarity, the latch loads mag_o = count, pol_o = polarity and ovr_o = 0, and status_o falls at that same edge.
- R7: If no crossing has occurred by the deintegrate edge with count 2^CNT_W-1, that edge loads mag_o = all ones, ovr_o = 1 and pol_o = polarity, status_o falls, and the sequencer returns to auto-zero.
- R8: After a crossing, any deintegrate edge that samples run_i low sends the sequencer to auto-zero at once. With run_i high, deintegrate runs its full 2^CNT_W edges. cmp_i is ignored after the crossing.
- R9: mag_o, pol_o and ovr_o change only on a latch load (R6 or R7).
- R10: status_o is high throughout integrate and is set only on entry to integrate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run (high) / hold (low) control |
| cmp_i | input | 1 | Comparator level |
| status_o | output | 1 | Conversion busy flag |
| az_o | output | 1 | Auto-zero phase select |
| int_o | output | 1 | Integrate phase select |
| deint_o | output | 1 | Deintegrate phase select |
| mag_o | output | CNT_W | Latched magnitude |
| pol_o | output | 1 | Latched polarity |
| ovr_o | output | 1 | Latched overrange flag |

## Verification
The bench builds the sequencer with AZ_MIN=20, INT_LEN=16, CNT_W=6 and START_DLY=7. With these values a full conversion takes about a hundred cycles, so dozens of conversions fit in a short run. These include crossings at count zero and at count 63, overranges at 64 counts, deintegrate cut short after the crossing, and long holds in auto-zero. The start delay keeps its normal value of seven, so the exact cycle at which integrate starts after a run/hold edge is checked as specified.

// File: rtl/ds_seq_pkg.sv
package ds_seq_pkg;
  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } phase_e;
endpackage

// File: rtl/ds_az_gate.sv
module ds_az_gate #(
  parameter int AZ_MIN    = 1790,
  parameter int START_DLY = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_az_i,
  input  logic run_i,
  output logic start_o
);
  localparam int AZ_W  = $clog2(AZ_MIN + 1);
  localparam int DLY_W = $clog2(START_DLY + 1);

  logic [AZ_W-1:0]  az_q;
  logic [DLY_W-1:0] dly_q;
  logic             az_done, armed;

  assign az_done = (az_q == AZ_W'(AZ_MIN));
  // countdown commits once started
  assign armed   = in_az_i && az_done && (run_i || (dly_q != '0));
  assign start_o = armed && (dly_q == DLY_W'(START_DLY - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      az_q  <= '0;
      dly_q <= '0;
    end else if (!in_az_i) begin
      az_q  <= '0;
      dly_q <= '0;
    end else begin
      if (!az_done) az_q <= az_q + 1'b1;
      if (start_o)    dly_q <= '0;
      else if (armed) dly_q <= dly_q + 1'b1;
    end
  end

  a_r4_countdown_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_az_i && dly_q != '0 && !start_o) |=> (dly_q != '0 || start_o || !in_az_i));
endmodule

// File: rtl/ds_slope_ctr.sv
module ds_slope_ctr #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ds_result_latch.sv
module ds_result_latch #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] mag_i,
  input  logic         pol_i,
  input  logic         ovr_i,
  output logic [W-1:0] mag_o,
  output logic         pol_o,
  output logic         ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_o <= '0;
      pol_o <= 1'b0;
      ovr_o <= 1'b0;
    end else if (load_i) begin
      mag_o <= mag_i;
      pol_o <= pol_i;
      ovr_o <= ovr_i;
    end
  end

  a_r9_hold_between_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable({mag_o, pol_o, ovr_o}));
  a_r7_ovr_full_scale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> (&mag_o));
endmodule

// File: rtl/ds_seq.sv
module ds_seq
  import ds_seq_pkg::*;
#(
  parameter int AZ_MIN    = 1790,
  parameter int INT_LEN   = 2048,
  parameter int CNT_W     = 12,
  parameter int START_DLY = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cmp_i,
  output logic             status_o,
  output logic             az_o,
  output logic             int_o,
  output logic             deint_o,
  output logic [CNT_W-1:0] mag_o,
  output logic             pol_o,
  output logic             ovr_o
);
  localparam int INT_W  = $clog2(INT_LEN);
  localparam int CTR_W  = (CNT_W > INT_W) ? CNT_W : INT_W;
  localparam int FULL   = (1 << CNT_W) - 1;
  localparam int LEN_LIM = AZ_MIN + START_DLY;
  localparam int LEN_W  = $clog2(LEN_LIM + 1);

  phase_e           phase_q;
  logic             pol_int_q, crossed_q, status_q;
  logic [CTR_W-1:0] cnt;
  logic             in_az, start, int_last, de_last, zc, ovf, load, leave_de;
  logic [CNT_W-1:0] lat_mag;

  assign in_az    = (phase_q == PH_AZ);
  assign int_last = (phase_q == PH_INT) && (cnt == CTR_W'(INT_LEN - 1));
  assign de_last  = (phase_q == PH_DEINT) && (cnt == CTR_W'(FULL));
  assign zc       = (phase_q == PH_DEINT) && !crossed_q && (cmp_i != pol_int_q);
  assign ovf      = de_last && !crossed_q && !zc;
  assign load     = zc || ovf;
  // cut short once crossed and run/hold is low
  assign leave_de = (phase_q == PH_DEINT) && (de_last || (crossed_q && !run_i));
  assign lat_mag  = ovf ? {CNT_W{1'b1}} : cnt[CNT_W-1:0];

  ds_az_gate #(.AZ_MIN(AZ_MIN), .START_DLY(START_DLY)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_az_i(in_az), .run_i(run_i), .start_o(start)
  );

  ds_slope_ctr #(.W(CTR_W)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(start || int_last || leave_de), .en_i(!in_az), .cnt_o(cnt)
  );

  ds_result_latch #(.W(CNT_W)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .mag_i(lat_mag), .pol_i(pol_int_q), .ovr_i(ovf),
    .mag_o(mag_o), .pol_o(pol_o), .ovr_o(ovr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_AZ;
      pol_int_q <= 1'b0;
      crossed_q <= 1'b0;
      status_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_AZ:    if (start) phase_q <= PH_INT;
        PH_INT:   if (int_last) phase_q <= PH_DEINT;
        PH_DEINT: if (leave_de) phase_q <= PH_AZ;
        default:  phase_q <= PH_AZ;
      endcase
      if (int_last) pol_int_q <= cmp_i;
      if (leave_de) crossed_q <= 1'b0;
      else if (zc)  crossed_q <= 1'b1;
      if (start)     status_q <= 1'b1;
      else if (load) status_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign az_o     = (phase_q == PH_AZ);
  assign int_o    = (phase_q == PH_INT);
  assign deint_o  = (phase_q == PH_DEINT);

  // assertion support: edges spent in auto-zero
  logic [LEN_W-1:0] az_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          az_len_q <= '0;
    else if (!az_o)                       az_len_q <= '0;
    else if (az_len_q != LEN_W'(LEN_LIM)) az_len_q <= az_len_q + 1'b1;
  end

  a_r2_one_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({az_o, int_o, deint_o}));
  a_r3_min_az_before_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_o) |-> (az_len_q == LEN_W'(LEN_LIM)));
  a_r4_status_with_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_o) |-> $rose(status_o));
  a_r10_status_in_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> status_o);
  a_r5_deint_after_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deint_o) |-> ($past(int_o) && status_o));
  a_r8_deint_exits_to_az: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(deint_o) |-> az_o);
endmodule

// File: tb/ds_seq_bench.sv
module ds_seq_bench;
  localparam int P_AZ  = 20;
  localparam int P_INT = 16;
  localparam int P_W   = 6;
  localparam int P_DLY = 7;
  localparam int MAXC  = (1 << P_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic cmp = 1'b0;
  logic status, az, intg, deint, pol, ovr;
  logic [P_W-1:0] mag;

  always #2 clk = ~clk;

  ds_seq #(.AZ_MIN(P_AZ), .INT_LEN(P_INT), .CNT_W(P_W), .START_DLY(P_DLY)) u_ds_seq (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cmp_i(cmp),
    .status_o(status), .az_o(az), .int_o(intg), .deint_o(deint),
    .mag_o(mag), .pol_o(pol), .ovr_o(ovr)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model, written from the requirements
  int m_phase, m_az, m_dly, m_cnt, m_mag;
  bit m_pol, m_crossed, m_status, m_opol, m_ovr;

  function automatic int phase_code(input bit a, input bit i, input bit d);
    return a ? 0 : (i ? 1 : (d ? 2 : 3));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_az = 0; m_dly = 0; m_cnt = 0; m_mag = 0;
      m_pol = 0; m_crossed = 0; m_status = 0; m_opol = 0; m_ovr = 0;
    end else begin
      case (m_phase)
        0: begin
          if (m_az < P_AZ) m_az++;
          else if (run || m_dly != 0) begin
            if (m_dly == P_DLY - 1) begin
              m_phase = 1; m_cnt = 0; m_dly = 0; m_status = 1;
            end else m_dly++;
          end
        end
        1: begin
          if (m_cnt == P_INT - 1) begin m_phase = 2; m_cnt = 0; m_pol = cmp; end
          else m_cnt++;
        end
        default: begin
          bit zc, last, leave;
          zc = !m_crossed && (cmp != m_pol);
          last = (m_cnt == MAXC);
          leave = last || (m_crossed && !run);
          if (zc) begin
            m_mag = m_cnt; m_opol = m_pol; m_ovr = 0; m_status = 0;
          end else if (!m_crossed && last) begin
            m_mag = MAXC; m_opol = m_pol; m_ovr = 1; m_status = 0;
          end
          if (leave) begin
            m_phase = 0; m_az = 0; m_dly = 0; m_crossed = 0;
          end else begin
            if (zc) m_crossed = 1;
            m_cnt++;
          end
        end
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(phase_code(az, intg, deint) == m_phase, "R2 R5 R8 phase",
          phase_code(az, intg, deint), m_phase);
      chk(status == m_status, "R4 R6 R10 status", status, m_status);
      chk(mag == P_W'(m_mag) && pol == m_opol && ovr == m_ovr, "R6 R7 R9 result",
          {mag, pol, ovr}, {P_W'(m_mag), m_opol, m_ovr});
    end
  end

  // automatic stimulus
  bit auto_drv = 0, picked = 0;
  int conv = 0, cross_at = 0, run_mode = 0;
  bit pol_sel = 0;

  always @(negedge clk) begin
    if (auto_drv) begin
      if (m_phase == 1 && !picked) begin
        picked = 1;
        pol_sel = 1'($urandom_range(0, 1));
        case (conv)
          0: begin cross_at = 0;        run_mode = 0; end
          1: begin cross_at = MAXC;     run_mode = 0; end
          2: begin cross_at = MAXC + 1; run_mode = 2; end
          3: begin cross_at = 5;        run_mode = 2; end
          default: begin
            cross_at = $urandom_range(0, MAXC + 10);
            run_mode = $urandom_range(0, 2);
          end
        endcase
        conv++;
      end
      if (m_phase != 1) picked = 0;
      if (m_phase == 1) cmp <= pol_sel;
      else if (m_phase == 2) cmp <= (m_cnt >= cross_at) ? !m_pol : m_pol;
      else cmp <= 1'($urandom_range(0, 1));
      case (run_mode)
        0: run <= 1'b1;
        1: run <= ($urandom_range(0, 3) != 0);
        default: run <= !(m_phase == 2 && m_crossed);
      endcase
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (!finished && wd < 60000) begin @(posedge clk); wd++; end
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7109));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(az && !intg && !deint, "R1 phase", phase_code(az, intg, deint), 0);
    chk(!status && mag == '0 && !pol && !ovr, "R1 status/latch",
        {status, mag, pol, ovr}, 0);
    rst_n = 1'b1;
    // R3: run pulse inside the minimum auto-zero is ignored
    repeat (2) @(negedge clk);
    run = 1'b1;
    repeat (3) @(negedge clk);
    run = 1'b0;
    repeat (60) @(negedge clk);
    chk(az && !status, "R3 run ignored in min auto-zero", {az, status}, 2'b10);
    // R4 hold with run low
    repeat (40) @(negedge clk);
    chk(az && !status, "R4 holds in auto-zero", {az, status}, 2'b10);
    // R4 start after seven edges, countdown commits despite run dropping
    run = 1'b1;
    repeat (2) @(negedge clk);
    run = 1'b0;
    repeat (4) @(negedge clk);
    chk(!status && az, "R4 not yet started at edge 6", {status, az}, 2'b01);
    @(negedge clk);
    chk(status && intg, "R4 started at edge 7", {status, intg}, 2'b11);
    // R5 integrate length
    repeat (P_INT - 1) @(negedge clk);
    chk(intg, "R5 still integrating", intg, 1);
    @(negedge clk);
    chk(deint, "R5 deintegrate after INT_LEN", deint, 1);
    auto_drv = 1;
    wait (conv >= 45);
    wait (m_phase == 0);
    repeat (150) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule